// File: doc/BRIEF.md
# Eight-Port Baseline Switching Network

This block is a blocking multistage interconnection network. It connects eight request ports to eight output ports through three stages of 2x2 switching elements, four elements per stage, wired in the baseline pattern. Each request carries a valid bit, a 3-bit destination tag, a 3-bit broadcast mask and a data word. Each element reads one tag bit and one mask bit from the requests it sees. From these it picks one of four settings: straight, exchange, upper broadcast or lower broadcast. Requests that lose a link to another request are dropped, and this is reported on a per-port blocked flag.

The stream rules are as follows. A request is offered when its `in_valid` bit is high at a rising clock edge. There is no ready signal on the request side, because the network holds no requests. After every request, one of two things happens one cycle later: its copies appear on the outputs, or its `blocked` bit is set. A source that sees `blocked` may offer the request again. The output side has no back-pressure, so the consumer must accept every output beat in the cycle it is shown. All paths through the network are combinational, and one register stage sits at the outputs.

Top module: `bnet_switch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, all `out_valid` bits and all `blocked` bits are 0.
- R2: A lone valid request with destination tag d and mask 000 appears at output d one clock after it is sampled. That output shows valid=1, `out_src` equal to the request's port number and `out_data` equal to its data. No other output is valid.
- R3: Stage 0 routes on tag bit 2 (the most significant bit), stage 1 on bit 1 and stage 2 on bit 0. Tag bit value 0 selects the upper element output. In stage s, element e takes link positions 2e and 2e+1 within blocks of 8>>s positions. The upper output of the element at local index k goes to block position k, and the lower output goes to block position k plus half the block.
- R4: When both inputs of one element are valid and their wanted outputs overlap, the request on the upper input (the even link position) keeps its outputs. The lower request is refused.
- R5: If a request has mask bit b set, the element of the stage that uses tag bit b drives that request to both of its outputs. An uncontested request therefore reaches every output whose number matches the tag on all bit positions where the mask is 0.
- R6: A request that is refused at any element for any of its copies is blocked as a whole. It appears at no output, including outputs its other copies reached, and its `blocked` bit is 1 in the same cycle its outputs would have appeared.
- R7: A port whose `in_valid` was 0 never has its `blocked` bit set in the following cycle.
- R8: Outputs and blocked flags change only at the clock edge. Each cycle's result depends only on the requests sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 8 | Request present, one bit per port |
| in_tag | input | 8x3 | Destination output number per port |
| in_bcast | input | 8x3 | Broadcast mask per port; bit b forks at the stage using tag bit b |
| in_data | input | 8x8 | Data word per port |
| out_valid | output | 8 | Output carries a delivered request |
| out_src | output | 8x3 | Port number of the delivered request |
| out_data | output | 8x8 | Data word of the delivered request |
| blocked | output | 8 | Request sampled last cycle on this port was refused |

## Verification
The bench builds the network with its default parameters: 3 tag bits (eight ports) and 8-bit data. With eight ports, each kind of element conflict can be reached within the three stages. These are lower-input refusal at the first, middle and last stage, broadcast forks that take both halves of the network, and a forked request whose copy loses deep inside the network while its other copy is still free. The random mix keeps broadcast masks sparse, so that multi-stage conflicts occur often without every cycle being flooded. The directed cases pin down the stage bit order and the wiring between stages.

// File: rtl/bnet_pkg.sv
package bnet_pkg;

  typedef enum logic [1:0] {
    SET_STRAIGHT = 2'd0,
    SET_EXCHANGE = 2'd1,
    SET_UPPER_BC = 2'd2,
    SET_LOWER_BC = 2'd3
  } elem_set_e;

  // Output-side wish of one request at one element: bit0 = upper out, bit1 = lower out
  function automatic logic [1:0] want_of(input logic vld, input logic tag_bit,
                                         input logic fork_bit);
    logic [1:0] w;
    if (!vld)          w = 2'b00;
    else if (fork_bit) w = 2'b11;
    else if (tag_bit)  w = 2'b10;
    else               w = 2'b01;
    return w;
  endfunction

endpackage

// File: rtl/bnet_elem.sv
module bnet_elem
  import bnet_pkg::*;
#(
  parameter int PORT_W  = 3,
  parameter int DATA_W  = 8,
  parameter int SEL_BIT = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   in_v,
  input  logic [1:0][PORT_W-1:0]       in_src,
  input  logic [1:0][PORT_W-1:0]       in_tag,
  input  logic [1:0][PORT_W-1:0]       in_mask,
  input  logic [1:0][DATA_W-1:0]       in_data,
  output logic [1:0]                   out_v,
  output logic [1:0][PORT_W-1:0]       out_src,
  output logic [1:0][PORT_W-1:0]       out_tag,
  output logic [1:0][PORT_W-1:0]       out_mask,
  output logic [1:0][DATA_W-1:0]       out_data,
  output logic                         refuse,
  output logic [PORT_W-1:0]            refuse_src
);

  logic [1:0] want_u, want_l, grant_l;
  logic       clash;
  elem_set_e  set_c;
  logic [1:0] sel;

  always_comb begin
    want_u  = want_of(in_v[0], in_tag[0][SEL_BIT], in_mask[0][SEL_BIT]);
    want_l  = want_of(in_v[1], in_tag[1][SEL_BIT], in_mask[1][SEL_BIT]);
    clash   = |(want_u & want_l);
    grant_l = clash ? 2'b00 : want_l;

    if (want_u == 2'b11)                 set_c = SET_UPPER_BC;
    else if (grant_l == 2'b11)           set_c = SET_LOWER_BC;
    else if (want_u[0] || grant_l[1])    set_c = SET_STRAIGHT;
    else if (want_u[1] || grant_l[0])    set_c = SET_EXCHANGE;
    else                                 set_c = SET_STRAIGHT;

    sel[0] = !(set_c == SET_STRAIGHT || set_c == SET_UPPER_BC);
    sel[1] = !(set_c == SET_EXCHANGE || set_c == SET_UPPER_BC);
  end

  for (genvar k = 0; k < 2; k++) begin : g_out
    assign out_v[k]    = want_u[k] | grant_l[k];
    assign out_src[k]  = in_src[sel[k]];
    assign out_tag[k]  = in_tag[sel[k]];
    assign out_mask[k] = in_mask[sel[k]];
    assign out_data[k] = in_data[sel[k]];
  end

  assign refuse     = clash;
  assign refuse_src = in_src[1];

  // R4: a refusal only arises between two live requests, and the upper one keeps a path
  a_r4_refuse_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |-> (in_v == 2'b11 &&
                ((out_v[0] && out_src[0] == in_src[0]) ||
                 (out_v[1] && out_src[1] == in_src[0]))));

  // R5: an upper request with its fork bit set owns both outputs
  a_r5_upper_fork: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v[0] && in_mask[0][SEL_BIT]) |->
      (out_v == 2'b11 && out_src[0] == in_src[0] && out_src[1] == in_src[0]));

  // R3: a unicast upper request leaves on the side its tag bit names
  a_r3_tag_side: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v[0] && !in_mask[0][SEL_BIT]) |->
      (out_v[in_tag[0][SEL_BIT]] && out_src[in_tag[0][SEL_BIT]] == in_src[0]));

endmodule

// File: rtl/bnet_stage.sv
module bnet_stage #(
  parameter int PORT_W = 3,
  parameter int DATA_W = 8,
  parameter int STAGE  = 0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [(1<<PORT_W)-1:0]             in_v,
  input  logic [(1<<PORT_W)-1:0][PORT_W-1:0] in_src,
  input  logic [(1<<PORT_W)-1:0][PORT_W-1:0] in_tag,
  input  logic [(1<<PORT_W)-1:0][PORT_W-1:0] in_mask,
  input  logic [(1<<PORT_W)-1:0][DATA_W-1:0] in_data,
  output logic [(1<<PORT_W)-1:0]             out_v,
  output logic [(1<<PORT_W)-1:0][PORT_W-1:0] out_src,
  output logic [(1<<PORT_W)-1:0][PORT_W-1:0] out_tag,
  output logic [(1<<PORT_W)-1:0][PORT_W-1:0] out_mask,
  output logic [(1<<PORT_W)-1:0][DATA_W-1:0] out_data,
  output logic [(1<<(PORT_W-1))-1:0]         refuse,
  output logic [(1<<(PORT_W-1))-1:0][PORT_W-1:0] refuse_src
);

  localparam int N_LINK  = 1 << PORT_W;
  localparam int N_ELEM  = N_LINK / 2;
  localparam int BLK     = N_LINK >> STAGE;
  localparam int HALF    = BLK / 2;
  localparam int SEL_BIT = PORT_W - 1 - STAGE;

  for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
    localparam int BASE = ((2 * e) / BLK) * BLK;
    localparam int LOC  = ((2 * e) % BLK) / 2;
    localparam int UP   = BASE + LOC;
    localparam int DN   = BASE + HALF + LOC;

    logic [1:0]             ev;
    logic [1:0][PORT_W-1:0] esrc, etag, emask;
    logic [1:0][DATA_W-1:0] edata;

    bnet_elem #(
      .PORT_W (PORT_W),
      .DATA_W (DATA_W),
      .SEL_BIT(SEL_BIT)
    ) i_elem (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_v      (in_v[2*e+1 -: 2]),
      .in_src    (in_src[2*e+1 -: 2]),
      .in_tag    (in_tag[2*e+1 -: 2]),
      .in_mask   (in_mask[2*e+1 -: 2]),
      .in_data   (in_data[2*e+1 -: 2]),
      .out_v     (ev),
      .out_src   (esrc),
      .out_tag   (etag),
      .out_mask  (emask),
      .out_data  (edata),
      .refuse    (refuse[e]),
      .refuse_src(refuse_src[e])
    );

    assign out_v[UP]    = ev[0];
    assign out_src[UP]  = esrc[0];
    assign out_tag[UP]  = etag[0];
    assign out_mask[UP] = emask[0];
    assign out_data[UP] = edata[0];
    assign out_v[DN]    = ev[1];
    assign out_src[DN]  = esrc[1];
    assign out_tag[DN]  = etag[1];
    assign out_mask[DN] = emask[1];
    assign out_data[DN] = edata[1];
  end

endmodule

// File: rtl/bnet_switch.sv
module bnet_switch #(
  parameter int PORT_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [(1<<PORT_W)-1:0]             in_valid,
  input  logic [(1<<PORT_W)-1:0][PORT_W-1:0] in_tag,
  input  logic [(1<<PORT_W)-1:0][PORT_W-1:0] in_bcast,
  input  logic [(1<<PORT_W)-1:0][DATA_W-1:0] in_data,
  output logic [(1<<PORT_W)-1:0]             out_valid,
  output logic [(1<<PORT_W)-1:0][PORT_W-1:0] out_src,
  output logic [(1<<PORT_W)-1:0][DATA_W-1:0] out_data,
  output logic [(1<<PORT_W)-1:0]             blocked
);

  localparam int N_LINK = 1 << PORT_W;
  localparam int N_ELEM = N_LINK / 2;
  localparam int N_STG  = PORT_W;

  logic [N_STG:0][N_LINK-1:0]             l_v;
  logic [N_STG:0][N_LINK-1:0][PORT_W-1:0] l_src, l_tag, l_mask;
  logic [N_STG:0][N_LINK-1:0][DATA_W-1:0] l_data;
  logic [N_STG-1:0][N_ELEM-1:0]             st_ref;
  logic [N_STG-1:0][N_ELEM-1:0][PORT_W-1:0] st_ref_src;
  logic [N_LINK-1:0]                        blocked_c;

  for (genvar i = 0; i < N_LINK; i++) begin : g_src
    assign l_src[0][i] = PORT_W'(i);
  end
  assign l_v[0]    = in_valid;
  assign l_tag[0]  = in_tag;
  assign l_mask[0] = in_bcast;
  assign l_data[0] = in_data;

  for (genvar s = 0; s < N_STG; s++) begin : g_stage
    bnet_stage #(
      .PORT_W(PORT_W),
      .DATA_W(DATA_W),
      .STAGE (s)
    ) i_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_v      (l_v[s]),
      .in_src    (l_src[s]),
      .in_tag    (l_tag[s]),
      .in_mask   (l_mask[s]),
      .in_data   (l_data[s]),
      .out_v     (l_v[s+1]),
      .out_src   (l_src[s+1]),
      .out_tag   (l_tag[s+1]),
      .out_mask  (l_mask[s+1]),
      .out_data  (l_data[s+1]),
      .refuse    (st_ref[s]),
      .refuse_src(st_ref_src[s])
    );
  end

  // Any refused copy marks its whole request as blocked
  always_comb begin
    blocked_c = '0;
    for (int s = 0; s < N_STG; s++) begin
      for (int e = 0; e < N_ELEM; e++) begin
        if (st_ref[s][e]) blocked_c[st_ref_src[s][e]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_src   <= '0;
      out_data  <= '0;
      blocked   <= '0;
    end else begin
      for (int j = 0; j < N_LINK; j++) begin
        out_valid[j] <= l_v[N_STG][j] && !blocked_c[l_src[N_STG][j]];
        out_src[j]   <= l_src[N_STG][j];
        out_data[j]  <= l_data[N_STG][j];
      end
      blocked <= blocked_c;
    end
  end

  // R1: reset clears both outputs and flags
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (out_valid == '0 && blocked == '0));

  // R8: an idle cycle yields no deliveries
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == '0) |=> (out_valid == '0 && blocked == '0));

  for (genvar j = 0; j < N_LINK; j++) begin : g_chk
    // R7: no request, no blocked flag
    a_r7_idle_not_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid[j] |=> !blocked[j]);
    // R6: a delivered source is never also flagged blocked
    a_r6_blocked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[j] |-> !blocked[out_src[j]]);
    // R5: whatever reaches final link j matches j on every non-forked tag bit
    a_r5_reach_set: assert property (@(posedge clk) disable iff (!rst_n)
      l_v[N_STG][j] |->
        (((l_tag[N_STG][j] ^ PORT_W'(j)) & ~l_mask[N_STG][j]) == '0));
  end

endmodule

// File: tb/test_bnet_switch.sv
module test_bnet_switch;

  localparam int PW     = 3;
  localparam int DW     = 8;
  localparam int NP     = 1 << PW;
  localparam int PERIOD = 10;
  localparam int N_RAND = 3000;

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b0;
  logic [NP-1:0]              in_valid = '0;
  logic [NP-1:0][PW-1:0]      in_tag = '0;
  logic [NP-1:0][PW-1:0]      in_bcast = '0;
  logic [NP-1:0][DW-1:0]      in_data = '0;
  logic [NP-1:0]              out_valid;
  logic [NP-1:0][PW-1:0]      out_src;
  logic [NP-1:0][DW-1:0]      out_data;
  logic [NP-1:0]              blocked;

  int n_tests = 0;
  int n_fail  = 0;

  logic [NP-1:0]         e_valid;
  logic [NP-1:0][PW-1:0] e_src;
  logic [NP-1:0][DW-1:0] e_data;
  logic [NP-1:0]         e_blk;

  always #(PERIOD/2) clk = ~clk;

  bnet_switch #(.PORT_W(PW), .DATA_W(DW)) i_bnet_switch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_bcast(in_bcast), .in_data(in_data), .out_valid(out_valid),
    .out_src(out_src), .out_data(out_data), .blocked(blocked)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected result from the routing rules R2..R6
  task automatic model();
    logic            v  [NP];
    logic [PW-1:0]   sr [NP];
    logic [PW-1:0]   tg [NP];
    logic [PW-1:0]   mk [NP];
    logic [DW-1:0]   dt [NP];
    logic            nv [NP];
    logic [PW-1:0]   nsr[NP];
    logic [PW-1:0]   ntg[NP];
    logic [PW-1:0]   nmk[NP];
    logic [DW-1:0]   ndt[NP];
    e_blk = '0;
    for (int i = 0; i < NP; i++) begin
      v[i] = in_valid[i]; sr[i] = PW'(i); tg[i] = in_tag[i];
      mk[i] = in_bcast[i]; dt[i] = in_data[i];
    end
    for (int s = 0; s < PW; s++) begin
      int b   = PW - 1 - s;
      int blk = NP >> s;
      for (int i = 0; i < NP; i++) begin
        nv[i] = 1'b0; nsr[i] = '0; ntg[i] = '0; nmk[i] = '0; ndt[i] = '0;
      end
      for (int e = 0; e < NP/2; e++) begin
        int a = 2*e;
        int c = 2*e + 1;
        logic [1:0] wu, wl, gl;
        int d0, d1;
        wu = !v[a] ? 2'b00 : mk[a][b] ? 2'b11 : tg[a][b] ? 2'b10 : 2'b01;
        wl = !v[c] ? 2'b00 : mk[c][b] ? 2'b11 : tg[c][b] ? 2'b10 : 2'b01;
        gl = wl;
        if ((wu & wl) != 0) begin
          e_blk[sr[c]] = 1'b1;
          gl = 2'b00;
        end
        d0 = (a / blk) * blk + (a % blk) / 2;
        d1 = d0 + blk / 2;
        for (int k = 0; k < 2; k++) begin
          int d = (k == 0) ? d0 : d1;
          if (wu[k]) begin
            nv[d] = 1'b1; nsr[d] = sr[a]; ntg[d] = tg[a]; nmk[d] = mk[a]; ndt[d] = dt[a];
          end else if (gl[k]) begin
            nv[d] = 1'b1; nsr[d] = sr[c]; ntg[d] = tg[c]; nmk[d] = mk[c]; ndt[d] = dt[c];
          end
        end
      end
      for (int i = 0; i < NP; i++) begin
        v[i] = nv[i]; sr[i] = nsr[i]; tg[i] = ntg[i]; mk[i] = nmk[i]; dt[i] = ndt[i];
      end
    end
    for (int j = 0; j < NP; j++) begin
      e_valid[j] = v[j] && !e_blk[sr[j]];
      e_src[j]   = sr[j];
      e_data[j]  = dt[j];
    end
  endtask

  // Inputs are already set (driven at a falling edge); sample after the next rising edge
  task automatic run_vec(input string req);
    model();
    @(posedge clk);
    @(negedge clk);
    check(req, "out_valid", 64'(out_valid), 64'(e_valid));
    check(req, "blocked",   64'(blocked),   64'(e_blk));
    for (int j = 0; j < NP; j++) begin
      if (e_valid[j] && out_valid[j]) begin
        check(req, $sformatf("src/data port %0d", j),
              64'({out_src[j], out_data[j]}), 64'({e_src[j], e_data[j]}));
      end
    end
  endtask

  task automatic clear_in();
    in_valid = '0; in_tag = '0; in_bcast = '0; in_data = '0;
  endtask

  task automatic put(input int p, input int tag, input int msk, input int dat);
    in_valid[p] = 1'b1;
    in_tag[p]   = PW'(tag);
    in_bcast[p] = PW'(msk);
    in_data[p]  = DW'(dat);
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h1bad_5eed));
    // R1: reset state, also with requests present
    put(0, 5, 0, 8'h11);
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", 64'(out_valid), 64'h0);
    check("R1", "blocked in reset",   64'(blocked),   64'h0);
    rst_n = 1'b1;
    clear_in();
    @(negedge clk);
    check("R1", "out_valid after reset", 64'(out_valid), 64'h0);
    check("R1", "blocked after reset",   64'(blocked),   64'h0);

    // R2: each lone unicast request, every destination
    for (int d = 0; d < NP; d++) begin
      clear_in();
      put((d * 3 + 1) % NP, d, 0, 8'hA0 + d);
      run_vec("R2");
      check("R2", "lone unicast at dest", 64'(out_valid), 64'(1) << d);
    end

    // R4: inputs 0 and 1 share a first-stage element, both want the upper side
    clear_in();
    put(0, 0, 0, 8'h01); put(1, 1, 0, 8'h02);
    run_vec("R4");
    check("R4", "lower input refused", 64'(blocked), 64'h02);

    // R3: distinct top bits do not clash in stage 0
    clear_in();
    put(0, 3, 0, 8'h33); put(1, 4, 0, 8'h44);
    run_vec("R3");
    check("R3", "split on bit 2", 64'(out_valid), 64'h18);

    // R3: inputs 0 and 2 meet at stage 1 element 0 through the wiring, port 2 loses
    clear_in();
    put(0, 0, 0, 8'h50); put(2, 1, 0, 8'h52);
    run_vec("R3");
    check("R3", "middle-stage clash", 64'(blocked), 64'h04);

    // R5: full broadcast reaches all outputs
    clear_in();
    put(3, 0, 7, 8'h77);
    run_vec("R5");
    check("R5", "mask 111 to all", 64'(out_valid), 64'hFF);

    // R5: last-stage fork reaches the pair 2,3
    clear_in();
    put(5, 2, 1, 8'h55);
    run_vec("R5");
    check("R5", "mask 001 pair", 64'(out_valid), 64'h0C);

    // R6: port 3 forks at stage 0, one copy loses at stage 1, other copy suppressed
    clear_in();
    put(0, 0, 0, 8'h0F); put(3, 0, 4, 8'h3F);
    run_vec("R6");
    check("R6", "partial loss drops all copies", 64'(out_valid), 64'h01);
    check("R6", "blocked flag", 64'(blocked), 64'h08);

    // R7: an idle port is never blocked even among clashes
    clear_in();
    put(0, 2, 0, 8'h10); put(1, 2, 0, 8'h11); put(4, 6, 0, 8'h14);
    run_vec("R7");
    check("R7", "idle ports unflagged", 64'(blocked & ~64'(8'h13)), 64'h0);

    // R8: idle cycle after traffic clears outputs
    clear_in();
    run_vec("R8");

    // Random traffic over R2..R8
    for (int n = 0; n < N_RAND; n++) begin
      clear_in();
      for (int p = 0; p < NP; p++) begin
        int r = int'($urandom % 8);
        int m = 0;
        if (r == 6) m = 1 << ($urandom % PW);
        else if (r == 7) m = int'($urandom % NP);
        if (($urandom % 4) != 0) put(p, int'($urandom % NP), m, int'($urandom % 256));
      end
      run_vec("R6");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule